// File: doc/BRIEF.md
# SPI NOR Program and Erase Sequencer

This block turns one host write request into the full command traffic an SPI NOR flash needs. The request carries a byte offset and a byte count, and the data arrives on a separate byte stream. Each time the write address lands on the start of an erase sector, the sequencer erases that sector. It then programs the data one page per frame. Before every erase and every page program it polls the flash status until the device is idle. It then sends a write-enable command, because each finished operation clears the device's write latch.

The block drives a byte-level shifter. It starts one byte exchange at a time with a start strobe and waits for the shifter's completion strobe. Chip select is held low for the whole of a frame and high for a guard interval between frames. Addresses go out most significant byte first, as three or four bytes, chosen per request. A request whose offset or count does not fall on a sector boundary is refused at once, and no frame is sent. An error reported by the shifter ends the operation. Completion is signalled by a one-cycle done pulse, with an error flag that is only valid together with done.

Top module: `nor_write_seq`

## Requirements
- R1: A request whose offset or count is not a multiple of the sector size (2**SECTOR_LG bytes) makes done and err high in the cycle after it is taken, and no byte is sent.
- R2: A status poll is a 2-byte frame: the opcode OP_RDSR, then 0x00. The device is busy when the second received byte ANDed with BUSY_MASK (default bit 0) is non-zero, and the poll repeats until it reads idle. The first received byte is ignored.
- R3: After each poll that reads idle, a 1-byte frame holding OP_WREN is sent, and the erase or program frame follows it. Every erase and every program is preceded by this pair.
- R4: When the current address (offset plus bytes already written) is a multiple of the sector size, an erase frame is sent before that address is programmed: OP_ERASE, then the address.
- R5: Data is programmed in frames of OP_PROG, then the address, then exactly 2**PAGE_LG stream bytes. The address advances by one page per frame until count bytes are written.
- R6: Addresses go out most significant byte first: 4 bytes when req_addr4 was 1 at request time, otherwise 3 bytes (the low 24 bits).
- R7: Chip select rises after the last byte of every frame and stays high for at least GAP_CYC+1 cycles (never less than one cycle) before the next frame. No byte is started while it is high.
- R8: A shifter error returned with a byte's completion ends the frame and the request: chip select goes high, no further frame is sent, and done comes with err high.
- R9: done is a single-cycle pulse. A request with count 0 completes with err low and sends nothing.
- R10: The data stream is consumed (wr_ready high) only while the data bytes of a program frame are being started. The total taken equals the count of a successful request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when the block is idle |
| req_offset | input | 32 | Byte offset of the write |
| req_count | input | 32 | Number of bytes to write |
| req_addr4 | input | 1 | 1 selects 4-byte address frames |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request failed; valid with done |
| wr_data | input | 8 | Data stream byte |
| wr_valid | input | 1 | Data stream byte available |
| wr_ready | output | 1 | Data byte taken when high together with wr_valid |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_start | output | 1 | Start exchange of spi_tx |
| spi_tx | output | 8 | Byte to transmit |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Byte received during the exchange |
| spi_err | input | 1 | Shifter error, valid with spi_done |

## Verification
The assertions check, on every cycle, the framing rules. A byte is never started or stream data taken outside a frame, and chip select never rises for just one cycle. They also check that a misaligned request is refused in the next cycle, that a shifter error raises chip select at once, and that done is a pulse. Only the bench scenarios can show the order and content of whole frames. This covers repeated polls while busy, an erase exactly at each sector start and not between, and page addresses and data in stream order. It also covers 3-byte versus 4-byte address frames and the early stop after an error.

// File: rtl/nor_write_seq.sv
module nor_write_seq #(
  parameter int          SECTOR_LG = 16,
  parameter int          PAGE_LG   = 8,
  parameter int          GAP_CYC   = 2,
  parameter logic [7:0]  OP_RDSR   = 8'h05,
  parameter logic [7:0]  OP_WREN   = 8'h06,
  parameter logic [7:0]  OP_ERASE  = 8'hD8,
  parameter logic [7:0]  OP_PROG   = 8'h02,
  parameter logic [7:0]  BUSY_MASK = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_offset,
  input  logic [31:0] req_count,
  input  logic        req_addr4,
  output logic        busy,
  output logic        done,
  output logic        err,
  input  logic [7:0]  wr_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  output logic        spi_cs_n,
  output logic        spi_start,
  output logic [7:0]  spi_tx,
  input  logic        spi_done,
  input  logic [7:0]  spi_rx,
  input  logic        spi_err
);
  localparam int PAGE  = 1 << PAGE_LG;
  localparam int IDX_W = $clog2(PAGE + 6);
  localparam int GAP_W = (GAP_CYC > 0) ? $clog2(GAP_CYC + 1) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_WAIT, S_GAP, S_FIN} st_t;
  typedef enum logic [1:0] {K_STAT, K_WEN, K_ERASE, K_PROG} kind_t;

  st_t              st;
  kind_t            kind;
  logic [IDX_W-1:0] idx, flen;
  logic [31:0]      addr, remain, sh;
  logic [GAP_W-1:0] gap_cnt;
  logic             a4, erased, stat_busy, fail, cs_n_q;
  logic [2:0]       ab, shn;
  logic             is_data, last, misaligned, sect_start;

  assign ab         = a4 ? 3'd4 : 3'd3;
  assign is_data    = (kind == K_PROG) && (idx > IDX_W'(ab));
  assign last       = (idx == flen - IDX_W'(1));
  assign misaligned = (|req_offset[SECTOR_LG-1:0]) || (|req_count[SECTOR_LG-1:0]);
  assign sect_start = (addr[SECTOR_LG-1:0] == '0);
  assign shn        = ab - idx[2:0];
  assign sh         = addr >> {shn, 3'b000};

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign err       = done & fail;
  assign spi_cs_n  = cs_n_q;
  assign wr_ready  = (st == S_SEND) && is_data;
  assign spi_start = (st == S_SEND) && (!is_data || wr_valid);

  always_comb begin
    case (kind)
      K_STAT:  flen = IDX_W'(2);
      K_WEN:   flen = IDX_W'(1);
      K_ERASE: flen = IDX_W'(ab) + IDX_W'(1);
      default: flen = IDX_W'(ab) + IDX_W'(1) + IDX_W'(PAGE);
    endcase
  end

  always_comb begin
    if (idx == '0) begin
      case (kind)
        K_STAT:  spi_tx = OP_RDSR;
        K_WEN:   spi_tx = OP_WREN;
        K_ERASE: spi_tx = OP_ERASE;
        default: spi_tx = OP_PROG;
      endcase
    end else if (kind == K_STAT || kind == K_WEN) spi_tx = 8'h00;
    else if (is_data)                             spi_tx = wr_data;
    else                                          spi_tx = sh[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_PROG; idx <= '0; addr <= '0; remain <= '0;
      gap_cnt <= '0; a4 <= 1'b0; erased <= 1'b0; stat_busy <= 1'b0;
      fail <= 1'b0; cs_n_q <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          if (misaligned) begin
            fail <= 1'b1; st <= S_FIN;
          end else begin
            fail <= 1'b0; addr <= req_offset; remain <= req_count;
            a4 <= req_addr4; erased <= 1'b0; kind <= K_PROG;
            gap_cnt <= '0; st <= S_GAP;
          end
        end
        S_SEND: if (spi_start) st <= S_WAIT;
        S_WAIT: if (spi_done) begin
          if (kind == K_STAT && idx == IDX_W'(1)) stat_busy <= |(spi_rx & BUSY_MASK);
          if (spi_err) begin
            fail <= 1'b1; cs_n_q <= 1'b1; gap_cnt <= GAP_W'(GAP_CYC); st <= S_GAP;
          end else if (last) begin
            cs_n_q <= 1'b1; gap_cnt <= GAP_W'(GAP_CYC); st <= S_GAP;
            if (kind == K_ERASE) erased <= 1'b1;
            if (kind == K_PROG) begin
              addr <= addr + 32'(PAGE); remain <= remain - 32'(PAGE); erased <= 1'b0;
            end
          end else begin
            idx <= idx + IDX_W'(1); st <= S_SEND;
          end
        end
        S_GAP: begin
          if (gap_cnt != '0) gap_cnt <= gap_cnt - GAP_W'(1);
          else if (fail) st <= S_FIN;
          else begin
            idx <= '0;
            case (kind)
              K_STAT: begin
                kind <= stat_busy ? K_STAT : K_WEN; st <= S_SEND; cs_n_q <= 1'b0;
              end
              K_WEN: begin
                kind <= (sect_start && !erased) ? K_ERASE : K_PROG;
                st <= S_SEND; cs_n_q <= 1'b0;
              end
              default: if (remain == '0) st <= S_FIN;
                       else begin kind <= K_STAT; st <= S_SEND; cs_n_q <= 1'b0; end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req_valid && misaligned) |=> (done && err && spi_cs_n));
  p_start_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !spi_cs_n);
  p_gap_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);
  p_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && spi_done && spi_err) |=> (spi_cs_n && !spi_start));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ready_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!spi_cs_n && kind == K_PROG));
endmodule

// File: tb/nor_write_seq_tb_top.sv
module nor_write_seq_tb_top;
  localparam int SECTOR_LG = 6;
  localparam int PAGE_LG   = 4;
  localparam int GAP_CYC   = 2;
  localparam int SECTOR    = 1 << SECTOR_LG;
  localparam int PAGE      = 1 << PAGE_LG;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_addr4 = 1'b0;
  logic [31:0] req_offset = '0, req_count = '0;
  logic busy, done, err, wr_ready, wr_valid, spi_cs_n, spi_start;
  logic [7:0] wr_data, spi_tx, spi_rx;
  logic spi_done, spi_err;

  always #10 clk = ~clk;

  nor_write_seq #(.SECTOR_LG(SECTOR_LG), .PAGE_LG(PAGE_LG), .GAP_CYC(GAP_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .req_count(req_count), .req_addr4(req_addr4), .busy(busy), .done(done), .err(err),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .spi_cs_n(spi_cs_n),
    .spi_start(spi_start), .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx),
    .spi_err(spi_err));

  int n_chk = 0, n_fail = 0;
  logic clr = 1'b0, stall = 1'b0, tog = 1'b0;
  int busy_n = 0, err_at = -1;
  int ptr = 0;

  function automatic logic [7:0] dval(input int k);
    return 8'((k * 29) + 7);
  endfunction

  assign wr_data  = dval(ptr);
  assign wr_valid = stall ? tog : 1'b1;

  always @(posedge clk) begin
    tog <= ~tog;
    if (clr) ptr <= 0;
    else if (wr_ready && wr_valid) ptr <= ptr + 1;
  end

  logic [7:0] log_b [0:4095];
  int fr_start [0:255];
  int fr_len   [0:255];
  int nfr = 0, nb = 0, fbyte = 0, stat_seen = 0, byte_seen = 0;
  int gap_run = 0, min_gap = 1000, pend = 0;
  logic [7:0] prep_rx = 8'h00;
  logic prep_err = 1'b0;

  initial begin spi_done = 1'b0; spi_err = 1'b0; spi_rx = 8'h00; end

  always @(negedge clk) begin
    spi_done <= 1'b0; spi_err <= 1'b0;
    if (clr) begin
      nfr = 0; nb = 0; fbyte = 0; stat_seen = 0; byte_seen = 0;
      gap_run = 0; min_gap = 1000; pend = 0;
    end else begin
      if (spi_cs_n) begin
        fbyte = 0; gap_run++;
      end else if (gap_run > 0) begin
        if (nfr > 0 && gap_run < min_gap) min_gap = gap_run;
        gap_run = 0;
      end
      if (pend == 1) begin
        spi_done <= 1'b1; spi_rx <= prep_rx; spi_err <= prep_err; pend = 0;
      end else if (pend > 1) pend--;
      if (spi_start) begin
        if (fbyte == 0) begin fr_start[nfr] = nb; fr_len[nfr] = 0; nfr++; end
        log_b[nb] = spi_tx; nb++; fr_len[nfr-1]++;
        prep_rx = 8'hFF;
        if (fbyte == 1 && log_b[fr_start[nfr-1]] == 8'h05) begin
          prep_rx = (stat_seen < busy_n) ? 8'hFD : 8'hFE;
          stat_seen++;
        end
        prep_err = (byte_seen == err_at);
        byte_seen++; fbyte++; pend = 2;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_frame(input int fi, input int kind, input int a, input bit a4,
                           input int dbase, input string req);
    logic [7:0] e [0:63];
    int n, bad;
    if (kind == 0) begin e[0] = 8'h05; e[1] = 8'h00; n = 2; end
    else if (kind == 1) begin e[0] = 8'h06; n = 1; end
    else begin
      e[0] = (kind == 2) ? 8'hD8 : 8'h02; n = 1;
      if (a4) begin e[n] = 8'(a >> 24); n++; end
      e[n] = 8'(a >> 16); e[n+1] = 8'(a >> 8); e[n+2] = 8'(a); n += 3;
      if (kind == 3) for (int i = 0; i < PAGE; i++) begin e[n] = dval(dbase + i); n++; end
    end
    if (fi >= nfr) chk(1'b0, req, $sformatf("frame %0d missing, frames", fi), nfr, fi + 1);
    else if (fr_len[fi] != n) chk(1'b0, req, $sformatf("frame %0d length", fi), fr_len[fi], n);
    else begin
      bad = -1;
      for (int i = 0; i < n; i++)
        if (bad < 0 && log_b[fr_start[fi] + i] != e[i]) bad = i;
      if (bad < 0) chk(1'b1, req, "frame", 0, 0);
      else chk(1'b0, req, $sformatf("frame %0d byte %0d", fi, bad),
               log_b[fr_start[fi] + bad], e[bad]);
    end
  endtask

  task automatic check_write(input int off, input int cnt, input bit a4, input int bn,
                             input string areq);
    int fi = 0;
    bit first = 1'b1;
    for (int a = off; a < off + cnt; a += PAGE) begin
      if (a % SECTOR == 0) begin
        for (int s = 0; s < (first ? bn + 1 : 1); s++) begin chk_frame(fi, 0, 0, 0, 0, "R2"); fi++; end
        first = 1'b0;
        chk_frame(fi, 1, 0, 0, 0, "R3"); fi++;
        chk_frame(fi, 2, a, a4, 0, {"R4 ", areq}); fi++;
      end
      chk_frame(fi, 0, 0, 0, 0, "R2"); fi++;
      chk_frame(fi, 1, 0, 0, 0, "R3"); fi++;
      chk_frame(fi, 3, a, a4, a - off, {"R5 ", areq}); fi++;
    end
    chk(nfr == fi, "R5", "frame count", nfr, fi);
  endtask

  task automatic clear_log();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); @(negedge clk); clr = 1'b0;
  endtask

  task automatic run_req(input int off, input int cnt, input bit a4, output bit e_out,
                         output int dpulses);
    int n = 0;
    req_offset = off; req_count = cnt; req_addr4 = a4; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    while (!done && n < 50000) begin @(negedge clk); n++; end
    chk(done, "R9", "done seen", done, 1);
    e_out = err;
    dpulses = 0;
    @(negedge clk); if (done) dpulses++;
    chk(dpulses == 0, "R9", "done width", dpulses, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(spi_cs_n == 1'b1, "R7", "reset cs_n", spi_cs_n, 1);
    chk(!done && !busy && !wr_ready && !spi_start, "R9", "reset outputs",
        {done, busy, wr_ready, spi_start}, 0);
  endtask

  task automatic t_reject(input int off, input int cnt, input string what);
    bit e; int dp;
    clear_log();
    run_req(off, cnt, 1'b0, e, dp);
    chk(e == 1'b1, "R1", {what, " err"}, e, 1);
    chk(nfr == 0, "R1", {what, " frames sent"}, nfr, 0);
    chk(ptr == 0, "R10", {what, " stream taken"}, ptr, 0);
  endtask

  task automatic t_zero();
    bit e; int dp;
    clear_log();
    run_req(0, 0, 1'b0, e, dp);
    chk(e == 1'b0, "R9", "zero count err", e, 0);
    chk(nfr == 0, "R9", "zero count frames", nfr, 0);
  endtask

  task automatic t_write(input int off, input int cnt, input bit a4, input int bn,
                         input bit st_en, input string areq);
    bit e; int dp;
    clear_log();
    busy_n = bn; stall = st_en; err_at = -1;
    run_req(off, cnt, a4, e, dp);
    chk(e == 1'b0, "R5", "write err", e, 0);
    check_write(off, cnt, a4, bn, areq);
    chk(min_gap >= GAP_CYC + 1, "R7", "min cs high gap", min_gap, GAP_CYC + 1);
    chk(ptr == cnt, "R10", "stream bytes taken", ptr, cnt);
    stall = 1'b0; busy_n = 0;
  endtask

  task automatic t_spi_error();
    bit e; int dp;
    clear_log();
    busy_n = 0; err_at = 4;
    run_req(0, 64, 1'b0, e, dp);
    chk(e == 1'b1, "R8", "error status", e, 1);
    chk(nfr == 3, "R8", "frames after error", nfr, 3);
    if (nfr == 3) chk(fr_len[2] == 2, "R8", "cut frame length", fr_len[2], 2);
    chk(spi_cs_n == 1'b1, "R8", "cs after error", spi_cs_n, 1);
    chk(ptr == 0, "R10", "stream after error", ptr, 0);
    err_at = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reject(32'h90, 64, "offset");
    t_reject(0, 32'h50, "count");
    t_zero();
    t_write(32'h80, 128, 1'b0, 2, 1'b1, "R6");
    t_write(32'h0100_0040, 64, 1'b1, 0, 1'b0, "R6");
    t_write(32'h40, 128, 1'b0, 1, 1'b0, "R6");
    t_spi_error();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule